// File: doc/BRIEF.md
# IrDA SIR Pulse Modulator

This block sits between a UART transmitter and an infrared LED driver. For each bit cell of the transmit stream it emits a short active-high pulse when the bit is 0 and keeps the line low when the bit is 1. The pulse width comes from one of two sources. In variable mode the width is three ticks of the 16x baud tick, which is 3/16 of the current bit period. In fixed mode the width is three half-periods of an internal IR clock. That clock is the peripheral clock divided by 2N+2, where N is a 4-bit divisor field. With a 14.7456 MHz peripheral clock and N = 7, the pulse is 24 cycles long. That equals 3/16 of a bit at 115200 baud, whatever baud rate is in use.

The block also holds the prescaler select for the baud-rate generator. It turns that select into a clock-enable strobe at the peripheral clock divided by 1, 4, 16 or 64. Configuration is written through a one-cycle strobe into a shadow copy. The copy moves into the working registers at the next bit-cell start, or at once while the transmitter is idle. A pulse that has already started is therefore never cut short or stretched.

Top module: `irda_pulse_mod`

## Requirements
- R1: After reset, ir_tx is 0 and brg_ce is 1 on every cycle, because the clock select resets to 00 (undivided). Fixed mode is off and N is 0.
- R2: When a bit cell starts with tx_bit = 1, ir_tx stays 0 for the whole cell.
- R3: In variable mode (cfg_fixed_pw = 0), a cell that starts with tx_bit = 0 raises ir_tx one cycle after the bit_start cycle. ir_tx then falls at the edge of the third tick16 after the start, so the pulse is high for 3 tick periods.
- R4: In variable mode the pulse width does not depend on cfg_div_n.
- R5: In fixed mode (cfg_fixed_pw = 1), the pulse raised by a 0 bit lasts exactly 3·(N+1) clock cycles, where N is cfg_div_n. tick16 has no effect on the width in this mode.
- R6: In fixed mode with N = 7, the pulse is 24 cycles, which is 3/16 of a 128-cycle bit.
- R7: cfg_clk_sel picks the brg_ce rate: 00 gives every cycle, 01 gives every 4th cycle, 10 gives every 16th cycle and 11 gives every 64th cycle, with even spacing.
- R8: A configuration written in the middle of a cell does not change the pulse of that cell. It takes effect from the next bit_start.
- R9: With tx_en = 0, ir_tx is 0 from the next cycle on. This holds even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that loads the cfg_* fields into the shadow copy |
| cfg_fixed_pw | input | 1 | 1 selects fixed-width pulses, 0 selects 3/16 of the bit |
| cfg_div_n | input | 4 | IR clock divisor N (IR clock = clk/(2N+2)) |
| cfg_clk_sel | input | 2 | Baud generator prescaler select |
| tick16 | input | 1 | 16x baud tick, one cycle wide |
| tx_en | input | 1 | High while the transmitter is sending |
| bit_start | input | 1 | One-cycle strobe at the start of each bit cell, coincident with a tick16 |
| tx_bit | input | 1 | Serial data bit of the current cell |
| ir_tx | output | 1 | Active-high infrared pulse output |
| brg_ce | output | 1 | Prescaled clock enable for the baud-rate generator |

## Verification
The assertions assume that every bit cell is longer than the pulse it carries. Under that assumption a new bit_start never arrives while ir_tx is high. They also assume that bit_start only comes on a cycle where tick16 is also high. The stimulus builds every cell from 16 tick16 strobes spaced 4 to 8 cycles apart, with bit_start on the first one. That gives cells of at least 64 cycles, which is longer than the longest fixed pulse of 48 cycles. Configuration strobes are placed both between cells and in the middle of cells. This checks that the staged copy is applied only at the next cell start.

// File: rtl/irda_pulse_mod.sv
module irda_pulse_mod #(
  parameter int DIV_W       = 4,
  parameter int PULSE_STEPS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_fixed_pw,
  input  logic [DIV_W-1:0] cfg_div_n,
  input  logic [1:0]       cfg_clk_sel,
  input  logic             tick16,
  input  logic             tx_en,
  input  logic             bit_start,
  input  logic             tx_bit,
  output logic             ir_tx,
  output logic             brg_ce
);
  localparam int STEP_W = $clog2(PULSE_STEPS + 1);
  localparam int PRE_W  = 6;

  logic             sh_fixed, act_fixed;
  logic [DIV_W-1:0] sh_n, act_n;
  logic [1:0]       sh_sel, act_sel;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [STEP_W-1:0] step_cnt;
  logic             ir_q;
  logic             half_tick, step;

  assign half_tick = (div_cnt == act_n);
  assign step      = act_fixed ? half_tick : tick16;
  assign ir_tx     = ir_q;

  always_comb begin
    case (act_sel)
      2'd0:    brg_ce = 1'b1;
      2'd1:    brg_ce = &pre_cnt[1:0];
      2'd2:    brg_ce = &pre_cnt[3:0];
      default: brg_ce = &pre_cnt[5:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_fixed  <= 1'b0;
      sh_n      <= '0;
      sh_sel    <= '0;
      act_fixed <= 1'b0;
      act_n     <= '0;
      act_sel   <= '0;
    end else begin
      if (cfg_wr) begin
        sh_fixed <= cfg_fixed_pw;
        sh_n     <= cfg_div_n;
        sh_sel   <= cfg_clk_sel;
      end
      if (bit_start || !tx_en) begin
        act_fixed <= sh_fixed;
        act_n     <= sh_n;
        act_sel   <= sh_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= 1'b0;
      div_cnt  <= '0;
      step_cnt <= '0;
    end else if (!tx_en) begin
      ir_q     <= 1'b0;
      div_cnt  <= '0;
      step_cnt <= '0;
    end else if (bit_start) begin
      ir_q     <= ~tx_bit;
      div_cnt  <= '0;
      step_cnt <= '0;
    end else if (ir_q) begin
      if (act_fixed) div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
      if (step) begin
        if (step_cnt == STEP_W'(PULSE_STEPS - 1)) ir_q <= 1'b0;
        else                                      step_cnt <= step_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irda_pulse_mod_chk.sv
module irda_pulse_mod_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic bit_start,
  input logic tx_bit,
  input logic ir_tx,
  input logic act_fixed
);
  logic [6:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_run <= '0;
    else if (!ir_tx)     hi_run <= '0;
    else if (hi_run != 7'h7f) hi_run <= hi_run + 1'b1;
  end

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !ir_tx);

  p_one_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && bit_start && tx_bit) |=> !ir_tx);

  p_zero_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && bit_start && !tx_bit) |=> ir_tx);

  p_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(tx_en && bit_start && !tx_bit));

  p_fixed_width_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fixed && ir_tx) |-> (hi_run < 7'd48));
endmodule

bind irda_pulse_mod irda_pulse_mod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_start(bit_start),
  .tx_bit(tx_bit), .ir_tx(ir_tx), .act_fixed(act_fixed)
);

// File: tb/tb_irda_pulse_mod.sv
module tb_irda_pulse_mod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_fixed_pw = 1'b0;
  logic [3:0] cfg_div_n = '0;
  logic [1:0] cfg_clk_sel = '0;
  logic       tick16 = 1'b0, tx_en = 1'b0, bit_start = 1'b0, tx_bit = 1'b1;
  logic       ir_tx, brg_ce;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_fixed = 0;
  int m_n = 0;

  always #2.5 clk = ~clk;

  irda_pulse_mod dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fixed_pw(cfg_fixed_pw),
    .cfg_div_n(cfg_div_n), .cfg_clk_sel(cfg_clk_sel), .tick16(tick16),
    .tx_en(tx_en), .bit_start(bit_start), .tx_bit(tx_bit),
    .ir_tx(ir_tx), .brg_ce(brg_ce)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_width(input bit b, input bit fx, input int n, input int p);
    if (b) return 0;
    return fx ? 3 * (n + 1) : 3 * p;
  endfunction

  function automatic int brg_div(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 16 : 64;
  endfunction

  task automatic write_cfg(input bit fx, input int n, input int sel);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_fixed_pw = fx; cfg_div_n = 4'(n); cfg_clk_sel = 2'(sel);
    m_fixed = fx; m_n = n;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send_cell(input bit b, input int p, input int wr_at,
                           input bit nfx, input int nn, input string tag);
    int hi = 0, first = -1, expw;
    bit cfx = m_fixed;
    int cn = m_n;
    tx_en = 1'b1;
    for (int c = 0; c < 16 * p; c++) begin
      @(negedge clk);
      if (ir_tx) begin hi++; if (first < 0) first = c; end
      tick16 = (c % p == 0); bit_start = (c == 0); tx_bit = b;
      cfg_wr = (c == wr_at);
      if (c == wr_at) begin
        cfg_fixed_pw = nfx; cfg_div_n = 4'(nn);
        m_fixed = nfx; m_n = nn;
      end
    end
    @(negedge clk);
    if (ir_tx) hi++;
    tick16 = 1'b0; bit_start = 1'b0; cfg_wr = 1'b0;
    expw = exp_width(b, cfx, cn, p);
    chk(hi == expw, tag, hi, expw);
    if (!b) chk(first == 1, {tag, " onset"}, first, 1);
  endtask

  task automatic check_brg(input int sel);
    int cnt = 0, last = -1, bad = 0, d;
    d = brg_div(sel);
    tx_en = 1'b0;
    write_cfg(m_fixed, m_n, sel);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 128; c++) begin
      @(negedge clk);
      if (brg_ce) begin
        if (last >= 0 && c - last != d) bad++;
        last = c; cnt++;
      end
    end
    chk(cnt == 128 / d, "R7 count", cnt, 128 / d);
    chk(bad == 0, "R7 spacing", bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ones = 0;
    bit rb, rfx;
    int rp, rn, rw;
    void'($urandom(32'h1f3a));
    repeat (3) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (brg_ce && !ir_tx) ones++;
    end
    chk(ones == 8, "R1 reset state", ones, 8);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(!ir_tx && brg_ce, "R1 after release", {ir_tx, brg_ce}, 1);
    end

    send_cell(1'b0, 4, -1, 0, 0, "R3 variable p4");
    send_cell(1'b1, 4, -1, 0, 0, "R2 one bit");
    send_cell(1'b0, 7, -1, 0, 0, "R3 variable p7");
    write_cfg(1'b0, 15, 0);
    send_cell(1'b0, 5, -1, 0, 0, "R4 n15 ignored");
    write_cfg(1'b0, 0, 0);
    send_cell(1'b0, 5, -1, 0, 0, "R4 n0 ignored");
    write_cfg(1'b1, 7, 0);
    send_cell(1'b0, 8, -1, 0, 0, "R6 n7 24 cycles");
    send_cell(1'b0, 4, -1, 0, 0, "R5 tick independent");
    write_cfg(1'b1, 0, 0);
    send_cell(1'b0, 4, -1, 0, 0, "R5 n0");
    write_cfg(1'b1, 15, 0);
    send_cell(1'b0, 4, -1, 0, 0, "R5 n15");
    send_cell(1'b1, 4, -1, 0, 0, "R2 one bit fixed");
    write_cfg(1'b1, 3, 0);
    send_cell(1'b0, 6, 4, 1, 10, "R8 mid write kept");
    send_cell(1'b0, 6, -1, 0, 0, "R8 applied next");
    send_cell(1'b0, 6, 5, 0, 2, "R8 mode change kept");
    send_cell(1'b0, 6, -1, 0, 0, "R8 mode applied");

    // R9: drop tx_en mid-pulse
    write_cfg(1'b0, 0, 0);
    @(negedge clk);
    tx_en = 1'b1; tick16 = 1'b1; bit_start = 1'b1; tx_bit = 1'b0;
    @(negedge clk);
    tick16 = 1'b0; bit_start = 1'b0;
    chk(ir_tx == 1'b1, "R9 pulse up", ir_tx, 1);
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(ir_tx == 1'b0, "R9 idle forces low", ir_tx, 0);
    repeat (20) begin
      @(negedge clk);
      chk(ir_tx == 1'b0, "R9 stays low", ir_tx, 0);
    end

    check_brg(1);
    check_brg(2);
    check_brg(3);
    check_brg(0);

    for (int i = 0; i < 40; i++) begin
      rb = 1'($urandom_range(0, 1));
      rfx = 1'($urandom_range(0, 1));
      rn = $urandom_range(0, 15);
      rp = $urandom_range(4, 8);
      if ($urandom_range(0, 2) == 0) write_cfg(rfx, rn, 0);
      rw = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 40) : -1;
      send_cell(rb, rp, rw, 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                rb ? "R2 random" : (m_fixed ? "R5 random" : "R3 random"));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule